// File: doc/BRIEF.md
# Superscalar Issue Window Selector

This block keeps up to eight decoded instructions in program order and, every cycle, chooses up to four of them to send to execution. Each entry names one destination register, two source registers and an execution class: fixed point, floating point or load/store. An entry may issue only when no register it reads is marked busy in an external scoreboard and it has no register conflict with any older entry that stays behind in the window that cycle. Each class also has a fixed number of issue slots per cycle.

Issue is combinational from the registered window contents and the scoreboard. Issued entries leave the window at the next clock edge. The survivors close up with their order kept, and instructions accepted from the input lanes are appended behind them. The front end offers up to four instructions per cycle through a valid/ready handshake. Ready depends only on how much room is left once this cycle's issue is taken into account.

Top module: `iw_select`

## Requirements
- R1: After reset, and whenever reset is applied again, the window is empty: no issue slot is valid and `in_ready` is high.
- R2: An instruction is 25 bits wide. The tag is in [24:17], the destination in [16:12], source A in [11:7], source B in [6:2] and the class in [1:0]. Lane or slot k occupies bits [25k+24:25k]. Valid issue slots are contiguous from slot 0 and hold the issued entries oldest first.
- R3: An entry whose source A or source B register has its `busy_regs` bit set is not issued.
- R4: An entry is not issued while an older unissued entry writes a register that the entry reads (read-after-write).
- R5: An entry is not issued while it writes a register that an older unissued entry reads (write-after-read).
- R6: An entry is not issued while an older unissued entry writes the same destination (write-after-write).
- R7: One cycle issues at most two class-2 (load/store) entries, one class-1 (floating point) entry and one fixed-point entry, where class 0 and class 3 both count as fixed point. When more entries qualify than there are slots, the older ones win.
- R8: An older entry that issues in the same cycle imposes none of the hazards of R4 to R6 on younger entries.
- R9: Issued entries are gone from the window from the next cycle on. The remaining entries keep their relative order, and accepted instructions are placed after them in lane order.
- R10: `in_ready` is high exactly when the free entries, counted after this cycle's issue, number at least four. Nothing is written when `in_valid` or `in_ready` is low.
- R11: An accepted transfer takes lanes 0 to `in_count`-1 only. Lanes above that are ignored, and an `in_count` above 4 is treated as 4.
- R12: An entry that cannot issue does not stop a younger, independent entry from issuing in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | New instructions offered on the input lanes |
| in_count | input | 3 | Number of lanes in use, counted from lane 0 |
| in_instr | input | 100 | Four packed input lanes, lane 0 is the oldest |
| in_ready | output | 1 | Room for a full group of four after this cycle's issue |
| busy_regs | input | 32 | Scoreboard, one bit per register with a pending write |
| iss_valid | output | 4 | Valid flag for each issue slot |
| iss_instr | output | 100 | Four packed issue slots, slot 0 is the oldest issued |

## Verification
A corrupted window entry shows up as a wrong tag or field in an issue slot in the first cycle that entry is chosen. An error in occupancy shows up as an instruction that issues twice or never appears, or as `in_ready` taking the wrong value, within one cycle of the faulty update. Errors in the hazard or cap logic change the set of slots within the same cycle, so each stimulus group is checked in the cycle right after its load. Ordering faults in the close-up logic appear when a later cycle issues entries out of their accepted order, so the refill sequences follow the window until it is drained.

// File: rtl/iw_pkg.sv
package iw_pkg;

  localparam int REG_W = 5;
  localparam int NREG  = 1 << REG_W;
  localparam int TAG_W = 8;

  typedef enum logic [1:0] {
    CLS_FX  = 2'd0,
    CLS_FP  = 2'd1,
    CLS_LS  = 2'd2,
    CLS_AUX = 2'd3
  } cls_e;

  typedef struct packed {
    logic [TAG_W-1:0] tag;
    logic [REG_W-1:0] dst;
    logic [REG_W-1:0] src_a;
    logic [REG_W-1:0] src_b;
    cls_e             cls;
  } instr_t;

  localparam int IW = $bits(instr_t);

  localparam int POOL_FX = 0;
  localparam int POOL_FP = 1;
  localparam int POOL_LS = 2;

  // Resource pool used by a class; the spare code shares the fixed-point pool.
  function automatic int pool_of(cls_e c);
    case (c)
      CLS_LS:  return POOL_LS;
      CLS_FP:  return POOL_FP;
      default: return POOL_FX;
    endcase
  endfunction

  function automatic logic reads_reg(instr_t x, logic [REG_W-1:0] r);
    return (x.src_a == r) || (x.src_b == r);
  endfunction

  // True when the younger entry must stay behind the older one.
  function automatic logic must_follow(instr_t older, instr_t younger);
    logic raw, war, waw;
    raw = reads_reg(younger, older.dst);
    war = reads_reg(older, younger.dst);
    waw = (older.dst == younger.dst);
    return raw || war || waw;
  endfunction

  function automatic logic waits_on_busy(instr_t x, logic [NREG-1:0] busy);
    return busy[x.src_a] || busy[x.src_b];
  endfunction

endpackage

// File: rtl/iw_pick.sv
module iw_pick import iw_pkg::*; #(
  parameter int DEPTH   = 8,
  parameter int ISSUE_W = 4,
  parameter int LS_MAX  = 2,
  parameter int FP_MAX  = 1,
  parameter int FX_MAX  = 1,
  localparam int OCC_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  instr_t            win [DEPTH],
  input  logic [OCC_W-1:0]  occ,
  input  logic [NREG-1:0]   busy,
  output logic [DEPTH-1:0]  take,
  output logic [ISSUE_W-1:0] slot_valid,
  output instr_t            slot_instr [ISSUE_W],
  output logic [OCC_W-1:0]  n_take
);

  // Named internal events, one bit per window position.
  logic [DEPTH-1:0] busy_hit;
  logic [DEPTH-1:0] order_hit;
  logic [DEPTH-1:0] pool_full;

  int n_all, n_ls, n_fp, n_fx;
  int fill;

  // Walk oldest to youngest; each decision sees the decisions of older entries.
  always_comb begin
    take      = '0;
    busy_hit  = '0;
    order_hit = '0;
    pool_full = '0;
    n_all = 0;
    n_ls  = 0;
    n_fp  = 0;
    n_fx  = 0;
    for (int i = 0; i < DEPTH; i++) begin
      if (i < int'(occ)) begin
        busy_hit[i] = waits_on_busy(win[i], busy);
        for (int j = 0; j < i; j++) begin
          if (!take[j] && must_follow(win[j], win[i])) order_hit[i] = 1'b1;
        end
        case (pool_of(win[i].cls))
          POOL_LS: pool_full[i] = (n_ls >= LS_MAX);
          POOL_FP: pool_full[i] = (n_fp >= FP_MAX);
          default: pool_full[i] = (n_fx >= FX_MAX);
        endcase
        if (n_all >= ISSUE_W) pool_full[i] = 1'b1;
        if (!busy_hit[i] && !order_hit[i] && !pool_full[i]) begin
          take[i] = 1'b1;
          n_all++;
          case (pool_of(win[i].cls))
            POOL_LS: n_ls++;
            POOL_FP: n_fp++;
            default: n_fx++;
          endcase
        end
      end
    end
  end

  // Gather the chosen entries into the issue slots, oldest first.
  always_comb begin
    slot_valid = '0;
    for (int k = 0; k < ISSUE_W; k++) slot_instr[k] = '0;
    fill = 0;
    for (int i = 0; i < DEPTH; i++) begin
      if (take[i]) begin
        for (int k = 0; k < ISSUE_W; k++) begin
          if (k == fill) begin
            slot_valid[k] = 1'b1;
            slot_instr[k] = win[i];
          end
        end
        fill++;
      end
    end
    n_take = OCC_W'(fill);
  end

  // R7: the head of the window has no older entry and an empty pool, so it
  // must go whenever its sources are free.
  assert_oldest_goes_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (occ != '0) && !waits_on_busy(win[0], busy) |-> take[0]);

endmodule

// File: rtl/iw_compact.sv
module iw_compact import iw_pkg::*; #(
  parameter int DEPTH   = 8,
  parameter int ISSUE_W = 4,
  localparam int OCC_W  = $clog2(DEPTH + 1),
  localparam int CNT_W  = $clog2(ISSUE_W + 1)
) (
  input  instr_t             win [DEPTH],
  input  logic [OCC_W-1:0]   occ,
  input  logic [DEPTH-1:0]   take,
  input  logic               accept,
  input  logic [CNT_W-1:0]   lanes_used,
  input  instr_t             lane [ISSUE_W],
  output instr_t             nxt_win [DEPTH],
  output logic [OCC_W-1:0]   nxt_occ
);

  int wr;

  always_comb begin
    for (int p = 0; p < DEPTH; p++) nxt_win[p] = '0;
    wr = 0;
    // Survivors first, keeping their order.
    for (int i = 0; i < DEPTH; i++) begin
      if (i < int'(occ) && !take[i]) begin
        for (int p = 0; p < DEPTH; p++) begin
          if (p == wr) nxt_win[p] = win[i];
        end
        wr++;
      end
    end
    // Accepted lanes follow behind the survivors.
    for (int l = 0; l < ISSUE_W; l++) begin
      if (accept && l < int'(lanes_used) && wr < DEPTH) begin
        for (int p = 0; p < DEPTH; p++) begin
          if (p == wr) nxt_win[p] = lane[l];
        end
        wr++;
      end
    end
    nxt_occ = OCC_W'(wr);
  end

endmodule

// File: rtl/iw_select.sv
module iw_select import iw_pkg::*; #(
  parameter int DEPTH   = 8,
  parameter int ISSUE_W = 4,
  parameter int LS_MAX  = 2,
  parameter int FP_MAX  = 1,
  parameter int FX_MAX  = 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [$clog2(ISSUE_W+1)-1:0] in_count,
  input  logic [ISSUE_W*IW-1:0]   in_instr,
  output logic                    in_ready,
  input  logic [NREG-1:0]         busy_regs,
  output logic [ISSUE_W-1:0]      iss_valid,
  output logic [ISSUE_W*IW-1:0]   iss_instr
);

  localparam int OCC_W = $clog2(DEPTH + 1);
  localparam int CNT_W = $clog2(ISSUE_W + 1);

  instr_t             win_q [DEPTH];
  logic [OCC_W-1:0]   occ_q;
  instr_t             nxt_win [DEPTH];
  logic [OCC_W-1:0]   nxt_occ;
  logic [DEPTH-1:0]   take;
  logic [OCC_W-1:0]   n_take;
  instr_t             slot_instr [ISSUE_W];
  instr_t             lane [ISSUE_W];
  logic [CNT_W-1:0]   lanes_used;
  logic               accept;

  for (genvar k = 0; k < ISSUE_W; k++) begin : g_lanes
    assign lane[k] = instr_t'(in_instr[k*IW +: IW]);
    assign iss_instr[k*IW +: IW] = slot_instr[k];
  end

  assign lanes_used = (int'(in_count) > ISSUE_W) ? CNT_W'(ISSUE_W) : in_count;
  assign in_ready   = (DEPTH - int'(occ_q) + int'(n_take)) >= ISSUE_W;
  assign accept     = in_valid && in_ready;

  iw_pick #(
    .DEPTH(DEPTH), .ISSUE_W(ISSUE_W),
    .LS_MAX(LS_MAX), .FP_MAX(FP_MAX), .FX_MAX(FX_MAX)
  ) u_pick (
    .clk(clk), .rst_n(rst_n), .win(win_q), .occ(occ_q), .busy(busy_regs),
    .take(take), .slot_valid(iss_valid), .slot_instr(slot_instr), .n_take(n_take)
  );

  iw_compact #(.DEPTH(DEPTH), .ISSUE_W(ISSUE_W)) u_compact (
    .win(win_q), .occ(occ_q), .take(take), .accept(accept),
    .lanes_used(lanes_used), .lane(lane), .nxt_win(nxt_win), .nxt_occ(nxt_occ)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ_q <= '0;
      for (int i = 0; i < DEPTH; i++) win_q[i] <= '0;
    end else begin
      occ_q <= nxt_occ;
      win_q <= nxt_win;
    end
  end

  // Per-pool counts taken from the issue slots, independent of the picker's counters.
  int out_ls, out_fp, out_fx;
  always_comb begin
    out_ls = 0;
    out_fp = 0;
    out_fx = 0;
    for (int k = 0; k < ISSUE_W; k++) begin
      if (iss_valid[k]) begin
        case (pool_of(slot_instr[k].cls))
          POOL_LS: out_ls++;
          POOL_FP: out_fp++;
          default: out_fx++;
        endcase
      end
    end
  end

  assert_pool_caps_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_ls <= LS_MAX) && (out_fp <= FP_MAX) && (out_fx <= FX_MAX));

  assert_slots_packed_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid & (iss_valid + 1'b1)) == '0);

  assert_occ_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    int'(occ_q) <= DEPTH);

  assert_no_fill_unready_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |=> occ_q <= $past(occ_q));

  for (genvar k = 0; k < ISSUE_W; k++) begin : g_busy_chk
    assert_busy_src_R3: assert property (@(posedge clk) disable iff (!rst_n)
      iss_valid[k] |-> !waits_on_busy(slot_instr[k], busy_regs));
  end

endmodule

// File: tb/iw_select_tb_top.sv
module iw_select_tb_top;

  localparam int IW    = 25;
  localparam int LANES = 4;
  localparam int NR    = 32;
  localparam int BODY  = 17;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic                  in_valid;
  logic [2:0]            in_count;
  logic [LANES*IW-1:0]   in_instr;
  logic                  in_ready;
  logic [NR-1:0]         busy_regs;
  logic [LANES-1:0]      iss_valid;
  logic [LANES*IW-1:0]   iss_instr;

  int n_run  = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  iw_select dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_count(in_count),
    .in_instr(in_instr), .in_ready(in_ready), .busy_regs(busy_regs),
    .iss_valid(iss_valid), .iss_instr(iss_instr)
  );

  // Four instruction bodies {dst, src_a, src_b, cls}, instruction 0 in the low bits.
  // mask bit k set: instruction k (tag k+1) must issue in the cycle after loading.
  typedef struct packed {
    logic [4*BODY-1:0] body;
    logic [NR-1:0]     busy;
    logic [3:0]        mask;
  } vec_t;

  localparam vec_t VEC [9] = '{
    // 0: full mix, all independent (R7)
    '{body: {5'd4,5'd16,5'd17,2'd0, 5'd3,5'd14,5'd15,2'd1, 5'd2,5'd12,5'd13,2'd2, 5'd1,5'd10,5'd11,2'd2},
      busy: 32'h0, mask: 4'b1111},
    // 1: third load/store waits (R7)
    '{body: {5'd4,5'd16,5'd17,2'd0, 5'd3,5'd14,5'd15,2'd2, 5'd2,5'd12,5'd13,2'd2, 5'd1,5'd10,5'd11,2'd2},
      busy: 32'h0, mask: 4'b1011},
    // 2: busy source blocks 0, RAW blocks 1, younger go (R3, R4, R12)
    '{body: {5'd8,5'd15,5'd16,2'd2, 5'd7,5'd13,5'd14,2'd2, 5'd6,5'd5,5'd12,2'd1, 5'd5,5'd10,5'd11,2'd0},
      busy: 32'h0000_0400, mask: 4'b1100},
    // 3: WAR against stalled older entry (R5)
    '{body: {5'd10,5'd16,5'd17,2'd0, 5'd9,5'd14,5'd15,2'd2, 5'd20,5'd12,5'd13,2'd1, 5'd1,5'd20,5'd21,2'd0},
      busy: 32'h0020_0000, mask: 4'b1100},
    // 4: WAW against stalled older entry (R6)
    '{body: {5'd5,5'd16,5'd17,2'd0, 5'd4,5'd14,5'd15,2'd1, 5'd3,5'd12,5'd13,2'd0, 5'd3,5'd22,5'd11,2'd2},
      busy: 32'h0040_0000, mask: 4'b1100},
    // 5: hazards only against older entries that issue too (R8)
    '{body: {5'd10,5'd15,5'd16,2'd2, 5'd1,5'd13,5'd14,2'd2, 5'd2,5'd1,5'd12,2'd1, 5'd1,5'd10,5'd11,2'd0},
      busy: 32'h0, mask: 4'b1111},
    // 6: one float and one fixed slot (R7)
    '{body: {5'd4,5'd16,5'd17,2'd0, 5'd3,5'd14,5'd15,2'd0, 5'd2,5'd12,5'd13,2'd1, 5'd1,5'd10,5'd11,2'd1},
      busy: 32'h0, mask: 4'b0101},
    // 7: busy source B, RAW on source A of youngest (R3, R4)
    '{body: {5'd4,5'd1,5'd16,2'd1, 5'd3,5'd14,5'd15,2'd2, 5'd2,5'd12,5'd13,2'd2, 5'd1,5'd10,5'd11,2'd2},
      busy: 32'h0000_0800, mask: 4'b0110},
    // 8: class 3 uses the fixed-point slot (R7)
    '{body: {5'd4,5'd16,5'd17,2'd1, 5'd3,5'd14,5'd15,2'd2, 5'd2,5'd12,5'd13,2'd0, 5'd1,5'd10,5'd11,2'd3},
      busy: 32'h0, mask: 4'b1101}
  };

  function automatic string vec_req(int v);
    case (v)
      2:       return "R3/R4/R12";
      3:       return "R5";
      4:       return "R6";
      5:       return "R8";
      7:       return "R3/R4";
      default: return "R7";
    endcase
  endfunction

  task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n     = 1'b0;
    in_valid  = 1'b0;
    in_count  = '0;
    in_instr  = '0;
    busy_regs = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Independent group: dst = tag, sources 20 and 21 (never a destination here).
  task automatic load(int first_tag, int cnt, int cls);
    for (int k = 0; k < LANES; k++) begin
      in_instr[k*IW +: IW] = {8'(first_tag + k), 5'(first_tag + k), 5'd20, 5'd21, 2'(cls)};
    end
    in_count = 3'(cnt);
    in_valid = 1'b1;
  endtask

  task automatic expect_tags(string req, int n, int t0, int t1, int t2, int t3);
    int tg [4];
    logic [3:0] ev;
    tg[0] = t0; tg[1] = t1; tg[2] = t2; tg[3] = t3;
    ev = 4'((1 << n) - 1);
    check(iss_valid == ev, req, "iss_valid", 64'(iss_valid), 64'(ev));
    for (int k = 0; k < n; k++) begin
      check(iss_instr[k*IW + 17 +: 8] == 8'(tg[k]), req, $sformatf("slot%0d tag", k),
            64'(iss_instr[k*IW + 17 +: 8]), 64'(tg[k]));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [IW-1:0] exp_lane [4];
    logic [3:0]    exp_valid;
    int            s;

    // R1: reset state
    do_reset();
    #1;
    check(iss_valid == '0, "R1", "iss_valid after reset", 64'(iss_valid), 64'h0);
    check(in_ready == 1'b1, "R1", "in_ready after reset", 64'(in_ready), 64'h1);

    // Table of single-group selections
    for (int v = 0; v < 9; v++) begin
      do_reset();
      @(negedge clk);
      for (int k = 0; k < LANES; k++)
        in_instr[k*IW +: IW] = {8'(k + 1), VEC[v].body[k*BODY +: BODY]};
      in_count = 3'd4;
      in_valid = 1'b1;
      @(negedge clk);
      in_valid  = 1'b0;
      busy_regs = VEC[v].busy;
      #1;
      exp_valid = '0;
      for (int k = 0; k < 4; k++) exp_lane[k] = '0;
      s = 0;
      for (int k = 0; k < 4; k++) begin
        if (VEC[v].mask[k]) begin
          exp_lane[s]  = {8'(k + 1), VEC[v].body[k*BODY +: BODY]};
          exp_valid[s] = 1'b1;
          s++;
        end
      end
      check(iss_valid == exp_valid, vec_req(v), $sformatf("vec%0d iss_valid", v),
            64'(iss_valid), 64'(exp_valid));
      for (int k = 0; k < s; k++)
        check(iss_instr[k*IW +: IW] == exp_lane[k], vec_req(v), $sformatf("vec%0d slot%0d", v, k),
              64'(iss_instr[k*IW +: IW]), 64'(exp_lane[k]));
    end

    // R9/R10: close-up, refill and ready back-pressure
    do_reset();
    @(negedge clk); load(1, 4, 1); #1;
    check(in_ready == 1'b1, "R10", "ready on empty", 64'(in_ready), 64'h1);
    @(negedge clk); load(5, 4, 0); #1;
    expect_tags("R7", 1, 1, 0, 0, 0);
    check(in_ready == 1'b1, "R10", "ready with five free", 64'(in_ready), 64'h1);
    @(negedge clk); load(9, 4, 0); #1;
    expect_tags("R9", 2, 2, 5, 0, 0);
    check(in_ready == 1'b0, "R10", "ready with three free", 64'(in_ready), 64'h0);
    @(negedge clk); in_valid = 1'b0; #1;
    expect_tags("R9", 2, 3, 6, 0, 0);
    @(negedge clk); #1;
    expect_tags("R9", 2, 4, 7, 0, 0);
    @(negedge clk); #1;
    expect_tags("R9", 1, 8, 0, 0, 0);
    @(negedge clk); #1;
    expect_tags("R10", 0, 0, 0, 0, 0);

    // R11: partial lane count, upper lanes ignored; in_valid low ignored (R10)
    do_reset();
    @(negedge clk); load(1, 2, 2);
    @(negedge clk); in_valid = 1'b0; #1;
    expect_tags("R11", 2, 1, 2, 0, 0);
    @(negedge clk); #1;
    expect_tags("R11", 0, 0, 0, 0, 0);

    // R11: count above four treated as four
    do_reset();
    @(negedge clk); load(1, 7, 0);
    @(negedge clk); in_valid = 1'b0; #1;
    expect_tags("R11", 1, 1, 0, 0, 0);
    @(negedge clk); #1;
    expect_tags("R11", 1, 2, 0, 0, 0);
    @(negedge clk); #1;
    expect_tags("R11", 1, 3, 0, 0, 0);
    @(negedge clk); #1;
    expect_tags("R11", 1, 4, 0, 0, 0);
    @(negedge clk); #1;
    expect_tags("R11", 0, 0, 0, 0, 0);

    // R1: reset discards a loaded window
    do_reset();
    @(negedge clk); load(1, 4, 1);
    @(negedge clk); in_valid = 1'b0;
    do_reset();
    #1;
    check(iss_valid == '0, "R1", "iss_valid after second reset", 64'(iss_valid), 64'h0);
    check(in_ready == 1'b1, "R1", "in_ready after second reset", 64'(in_ready), 64'h1);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule